// File: doc/BRIEF.md
# Zero-Free Byte Stuffing Frame Encoder

This block turns a payload held in a local byte memory into a single frame in which no byte is zero except the closing delimiter. A start strobe carries the payload length. The block then reads the payload through a synchronous read port and writes the frame onto a byte-wide valid/ready stream. The payload is cut into blocks at every zero byte. Each block is sent as one code byte followed by the block's non-zero bytes, and the code byte tells the receiver how far away the next removed zero lies.

The code byte must go out before the bytes it describes. For this reason the encoder first scans forward from the start of each block to the next zero, to the end of the payload or to the run limit. It then rewinds and reads the same bytes a second time to send them. The output stage is one register. The byte and the valid flag are held while `out_ready_i` is low, and a byte moves only in a cycle where valid and ready are both high. Back-pressure from downstream never drops a byte and never repeats one. A single-cycle done pulse follows acceptance of the terminator.

Top module: `cobs_encoder`

## Requirements
- R1: Every block starts with a code byte equal to one plus the number of non-zero payload bytes before the next zero byte, or before the end of the payload (11 22 00 33 gives 03 11 22 02 33 00; 11 22 33 44 gives 05 11 22 33 44 00).
- R2: Zero payload bytes never appear in the output. The non-zero payload bytes appear in payload order, each exactly once (11 00 00 00 gives 02 11 01 01 01 00).
- R3: A frame ends with exactly one 0x00 byte, and no other output byte of the frame is 0x00.
- R4: A payload of length zero produces exactly the two bytes 01 00.
- R5: After 254 non-zero bytes in a row, a code byte 0xFF closes the block and a new block starts with no zero implied. If the payload ends right there, the terminator follows directly (bytes 01..FE give FF 01..FE 00; 255 non-zero bytes end in 02 xx 00).
- R6: A payload whose last byte is zero ends with the code byte 0x01 before the terminator (00 gives 01 01 00; 00 00 gives 01 01 01 00).
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` keeps its value in the following cycle.
- R8: `start_i` is taken only while `busy_o` is low. `busy_o` rises in the cycle after an accepted start, and a start strobe during a frame does not change that frame's output.
- R9: `done_o` is high for exactly one cycle, the cycle after the terminator is accepted. In that cycle `busy_o` is already low.
- R10: `rd_data_i` is expected one cycle after `rd_en_o`, and every read address is below the frame's length.
- R11: During and directly after reset, `out_valid_o`, `busy_o`, `done_o` and `rd_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame; taken only when idle |
| len_i | input | ADDR_W+1 | Payload length in bytes, sampled with start_i |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after the terminator is accepted |
| rd_en_o | output | 1 | Payload memory read strobe |
| rd_addr_o | output | ADDR_W | Payload memory read address |
| rd_data_i | input | 8 | Read data, valid one cycle after rd_en_o |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Downstream accepts out_data_o this cycle |

## Verification
Bytes become due only at transfer cycles, so a frame has no fixed latency. The bench samples at every falling edge. It decides the ready level for the coming rising edge, and whenever valid and ready are both high it compares the byte against the head of a queue filled by a behavioural encoder before the start. Busy is checked one cycle after start. Done and the low busy are checked one cycle after the terminator's transfer, and done must be low again one cycle later. Stall stability is checked on the cycle after every stalled one, and each read address is checked in the cycle its strobe is high.

// File: rtl/cobs_enc_pkg.sv
package cobs_enc_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MAX_RUN = 254;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SCAN_REQ,
    ST_SCAN_CHK,
    ST_CODE,
    ST_DATA_REQ,
    ST_DATA_OUT,
    ST_NEXT,
    ST_DELIM,
    ST_DRAIN
  } enc_state_e;

  typedef enum logic [1:0] {
    END_ZERO,
    END_LIMIT,
    END_EOF
  } run_end_e;

  typedef enum logic [2:0] {
    TC_HOLD,
    TC_INIT,
    TC_SCAN_ADV,
    TC_REWIND,
    TC_EMIT_ADV,
    TC_SKIP_ZERO,
    TC_NEW_BLOCK
  } trk_cmd_e;
endpackage

// File: rtl/cobs_run_tracker.sv
module cobs_run_tracker
  import cobs_enc_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  trk_cmd_e                cmd_i,
  input  logic [ADDR_W:0]         len_i,
  output logic [ADDR_W:0]         pos_o,
  output logic [BYTE_W-1:0]       run_o,
  output logic                    at_end_o,
  output logic                    run_full_o,
  output logic                    emit_last_o
);
  localparam int unsigned LEN_W = ADDR_W + 1;

  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  pos_q;
  logic [LEN_W-1:0]  blk_q;
  logic [BYTE_W-1:0] run_q;
  logic [LEN_W:0]    pos_next_wide;
  logic [LEN_W:0]    blk_end_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      pos_q <= '0;
      blk_q <= '0;
      run_q <= '0;
    end else begin
      unique case (cmd_i)
        TC_INIT: begin
          len_q <= len_i;
          pos_q <= '0;
          blk_q <= '0;
          run_q <= '0;
        end
        TC_SCAN_ADV: begin
          pos_q <= pos_q + 1'b1;
          run_q <= run_q + 1'b1;
        end
        TC_REWIND:   pos_q <= blk_q;
        TC_EMIT_ADV: pos_q <= pos_q + 1'b1;
        TC_SKIP_ZERO: begin
          pos_q <= pos_q + 1'b1;
          blk_q <= pos_q + 1'b1;
          run_q <= '0;
        end
        TC_NEW_BLOCK: begin
          blk_q <= pos_q;
          run_q <= '0;
        end
        default: ;
      endcase
    end
  end

  assign pos_next_wide = {1'b0, pos_q} + 1'b1;
  assign blk_end_wide  = {1'b0, blk_q} + {{(LEN_W + 1 - BYTE_W){1'b0}}, run_q};

  assign pos_o       = pos_q;
  assign run_o       = run_q;
  assign at_end_o    = (pos_q == len_q);
  assign run_full_o  = (run_q == BYTE_W'(MAX_RUN));
  assign emit_last_o = (pos_next_wide == blk_end_wide);

  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= BYTE_W'(MAX_RUN))
    else $error("run counter past limit");

  p_pos_in_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= len_q)
    else $error("position past payload end");
endmodule

// File: rtl/cobs_out_stage.sv
module cobs_out_stage
  import cobs_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  input  logic              load_last_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              last_o,
  output logic              free_o
);
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      last_q  <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= load_data_i;
      last_q  <= load_last_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign last_o  = last_q;
  assign free_o  = !valid_q || ready_i;

  p_load_when_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!valid_q || ready_i))
    else $error("load into occupied output register");

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q)))
    else $error("output changed under back-pressure");

  p_zero_only_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && data_q == '0) |-> last_q)
    else $error("zero byte inside frame");
endmodule

// File: rtl/cobs_encoder.sv
module cobs_encoder
  import cobs_enc_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W:0]   len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  input  logic              out_ready_i
);
  enc_state_e        state_q, state_d;
  run_end_e          end_q, end_d;
  trk_cmd_e          trk_cmd;
  logic [ADDR_W:0]   pos;
  logic [BYTE_W-1:0] run;
  logic              at_end, run_full, emit_last;
  logic              ld, ld_last, free, out_last;
  logic [BYTE_W-1:0] ld_data;
  logic              rd_en;
  logic              done_q;
  logic              term_taken;

  cobs_run_tracker #(.ADDR_W(ADDR_W)) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (trk_cmd),
    .len_i       (len_i),
    .pos_o       (pos),
    .run_o       (run),
    .at_end_o    (at_end),
    .run_full_o  (run_full),
    .emit_last_o (emit_last)
  );

  cobs_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (ld),
    .load_data_i (ld_data),
    .load_last_i (ld_last),
    .ready_i     (out_ready_i),
    .valid_o     (out_valid_o),
    .data_o      (out_data_o),
    .last_o      (out_last),
    .free_o      (free)
  );

  assign term_taken = (state_q == ST_DRAIN) && out_valid_o && out_ready_i;

  always_comb begin
    state_d = state_q;
    end_d   = end_q;
    trk_cmd = TC_HOLD;
    ld      = 1'b0;
    ld_data = '0;
    ld_last = 1'b0;
    rd_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          trk_cmd = TC_INIT;
          state_d = ST_SCAN_REQ;
        end
      end
      ST_SCAN_REQ: begin
        if (at_end) begin
          end_d   = END_EOF;
          state_d = ST_CODE;
        end else if (run_full) begin
          end_d   = END_LIMIT;
          state_d = ST_CODE;
        end else begin
          rd_en   = 1'b1;
          state_d = ST_SCAN_CHK;
        end
      end
      ST_SCAN_CHK: begin
        if (rd_data_i == '0) begin
          end_d   = END_ZERO;
          state_d = ST_CODE;
        end else begin
          trk_cmd = TC_SCAN_ADV;
          state_d = ST_SCAN_REQ;
        end
      end
      ST_CODE: begin
        if (free) begin
          ld      = 1'b1;
          ld_data = run + 1'b1;
          trk_cmd = TC_REWIND;
          state_d = (run == '0) ? ST_NEXT : ST_DATA_REQ;
        end
      end
      ST_DATA_REQ: begin
        if (free) begin
          rd_en   = 1'b1;
          state_d = ST_DATA_OUT;
        end
      end
      ST_DATA_OUT: begin
        ld      = 1'b1;
        ld_data = rd_data_i;
        trk_cmd = TC_EMIT_ADV;
        state_d = emit_last ? ST_NEXT : ST_DATA_REQ;
      end
      ST_NEXT: begin
        unique case (end_q)
          END_ZERO: begin
            trk_cmd = TC_SKIP_ZERO;
            state_d = ST_SCAN_REQ;
          end
          END_LIMIT: begin
            if (at_end) begin
              state_d = ST_DELIM;
            end else begin
              trk_cmd = TC_NEW_BLOCK;
              state_d = ST_SCAN_REQ;
            end
          end
          default: state_d = ST_DELIM;
        endcase
      end
      ST_DELIM: begin
        if (free) begin
          ld      = 1'b1;
          ld_data = '0;
          ld_last = 1'b1;
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (term_taken) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      end_q   <= END_EOF;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      end_q   <= end_d;
      done_q  <= term_taken;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign rd_en_o   = rd_en;
  assign rd_addr_o = pos[ADDR_W-1:0];

  p_done_after_term_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(out_valid_o && out_ready_i && out_last) && !busy_o))
    else $error("done without terminator transfer");

  p_read_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> !at_end)
    else $error("read beyond payload");

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !term_taken) |=> busy_o)
    else $error("frame abandoned before terminator");
endmodule

// File: tb/tb_cobs_encoder.sv
module tb_cobs_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 9;
  localparam int MEM_D      = 1 << ADDR_W;
  localparam int WD_LIMIT   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W:0]   len = '0;
  logic              busy, done, rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data = '0;
  logic              out_valid;
  logic [7:0]        out_data;
  logic              out_ready = 1'b0;

  logic [7:0] mem [MEM_D];
  logic [7:0] exp_q [$];
  int    n_cmp = 0, n_bad = 0;
  int    ready_mode = 0;
  int    cyc = 0;
  int    frames_done = 0;
  int    cur_len = 0;
  string cur_req = "R1";
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic       prev_done = 1'b0;

  cobs_encoder #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .len_i(len),
    .busy_o(busy), .done_o(done), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ready_i(out_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Behavioural reference encoder
  task automatic build_expected(input int n);
    logic [7:0] blk [$];
    bit flushed = 0;
    exp_q.delete();
    for (int i = 0; i < n; i++) begin
      if (mem[i] == 8'h00) begin
        exp_q.push_back(8'(blk.size() + 1));
        foreach (blk[k]) exp_q.push_back(blk[k]);
        blk.delete();
        flushed = 0;
      end else begin
        blk.push_back(mem[i]);
        flushed = 0;
        if (blk.size() == 254) begin
          exp_q.push_back(8'hFF);
          foreach (blk[k]) exp_q.push_back(blk[k]);
          blk.delete();
          flushed = 1;
        end
      end
    end
    if (!flushed) begin
      exp_q.push_back(8'(blk.size() + 1));
      foreach (blk[k]) exp_q.push_back(blk[k]);
    end
    exp_q.push_back(8'h00);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R7", "stalled byte held",
            {out_valid, out_data}, {1'b1, prev_data});
      if (done) begin
        chk(exp_q.size() == 0, "R9", "bytes left at done", exp_q.size(), 0);
        chk(!busy, "R9", "busy at done", busy, 0);
        frames_done++;
      end
      if (prev_done) chk(!done, "R9", "done longer than one cycle", done, 0);
      if (rd_en) chk(int'(rd_addr) < cur_len, "R10", "read address", rd_addr, cur_len);
      case (ready_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = (cyc % 3 == 0);
        default: out_ready = 1'($urandom % 2);
      endcase
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3", "byte after terminator", out_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, (e == 8'h00) ? "R3" : cur_req, "stream byte", out_data, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_done  = done;
    end
  end

  task automatic run_frame(input int n, input string req, input int mode, input bit poke);
    int target;
    cur_req = req;
    ready_mode = mode;
    cur_len = n;
    build_expected(n);
    target = frames_done + 1;
    @(negedge clk);
    start = 1'b1;
    len = (ADDR_W+1)'(n);
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8", "busy after start", busy, 1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1;
      len = (ADDR_W+1)'(3);
      @(negedge clk);
      start = 1'b0;
      len = (ADDR_W+1)'(n);
    end
    while (frames_done < target) @(negedge clk);
    @(negedge clk);
    chk(!out_valid && !busy, "R8", "idle after frame", {out_valid, busy}, 0);
  endtask

  task automatic load4(input logic [7:0] a, b, c, d);
    mem[0] = a; mem[1] = b; mem[2] = c; mem[3] = d;
  endtask

  initial begin
    for (int i = 0; i < MEM_D; i++) mem[i] = 8'h00;
    fork
      begin
        repeat (4) @(negedge clk);
        chk(!out_valid && !busy && !done && !rd_en, "R11", "reset outputs",
            {out_valid, busy, done, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !busy && !done && !rd_en, "R11", "after reset",
            {out_valid, busy, done, rd_en}, 0);

        mem[0] = 8'h00;                 run_frame(1, "R6", 0, 0);
        mem[0] = 8'h00; mem[1] = 8'h00; run_frame(2, "R6", 1, 0);
        load4(8'h11, 8'h22, 8'h00, 8'h33); run_frame(4, "R1", 0, 0);
        load4(8'h11, 8'h22, 8'h33, 8'h44); run_frame(4, "R1", 1, 0);
        load4(8'h11, 8'h00, 8'h00, 8'h00); run_frame(4, "R2", 2, 0);
        run_frame(0, "R4", 0, 0);
        for (int i = 0; i < 254; i++) mem[i] = 8'(i + 1);
        run_frame(254, "R5", 1, 0);
        mem[254] = 8'h5A;               run_frame(255, "R5", 2, 0);
        mem[254] = 8'h00;               run_frame(255, "R5", 0, 0);
        for (int i = 0; i < 400; i++)
          mem[i] = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom % 255 + 1);
        run_frame(400, "R2", 2, 1);
        for (int i = 0; i < 300; i++) mem[i] = 8'(i % 7 == 3 ? 0 : i % 251 + 1);
        run_frame(300, "R1", 1, 1);
      end
      begin
        repeat (WD_LIMIT) @(posedge clk);
        chk(0, "R8", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule